// File: doc/BRIEF.md
# Coupling-Aware Bus Transition Cost Monitor

This block sits beside an on-chip bus and accumulates a switching cost that reflects how the wires are actually loaded. Each wire sees a load to ground and also a lateral capacitance to each of its physical neighbours. The lateral charge depends on what the neighbour does in the same cycle. It doubles when the two wires move in opposite directions and vanishes when they move together. A plain toggle counter misses this effect. This monitor tracks the two parts of the cost separately.

On every cycle with the sample strobe high, the current bus word is compared with the last strobed word. Each wire is classified as rising, falling or idle. A switching wire is charged one unit of ground load. For each neighbour it is also charged coupling units: two if the neighbour moves the opposite way, one if the neighbour is idle, and none if the neighbour moves the same way. The charge is taken from the switching wire's own point of view, so an idle wire charges nothing even when its neighbour moves. The two edge wires have only one neighbour each. Both totals are kept in saturating counters. A combined figure, ground units plus an integer ratio times coupling units, is offered at the output. The coupling count on its own stands for the case where the ratio is unbounded.

Top module: `coupling_cost_mon`

## Requirements
- R1: After reset, both counters and the combined cost read zero.
- R2: The first strobed sample after reset or after a clear only records the word and adds nothing to either counter.
- R3: For each later strobed sample, the ground counter grows by the number of bit positions that differ from the previous strobed word.
- R4: For each switching wire, the coupling counter grows by a per-neighbour charge. The charge is 2 if the neighbour switches the opposite way, 0 if it switches the same way, and 1 if it is idle. An idle wire adds 0. Wire 0 has only wire 1 as a neighbour, and the top wire has only the wire below it.
- R5: With the strobe low, the counters hold and the recorded word is kept, so the next strobed sample is compared with the last strobed word.
- R6: A clear zeroes both counters and re-arms the first-sample rule of R2. When clear and strobe are high in the same cycle, the clear wins and the sample is dropped.
- R7: The combined cost equals ground count plus ratio input times coupling count, saturated at all ones. With a ratio of 0 it equals the ground count.
- R8: Each counter saturates at all ones and never wraps.
- R9: A strobed sample shows up in the counters in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and first-sample state |
| smp_vld | input | 1 | Sample strobe for the bus word |
| bus_in | input | WIDTH | Observed bus word |
| eta | input | ETA_W | Integer ratio of lateral to ground capacitance |
| self_cnt | output | CNT_W | Accumulated ground-load transition units |
| coup_cnt | output | CNT_W | Accumulated lateral coupling units |
| cost_out | output | CNT_W | Ground count plus ratio times coupling count, saturated |

## Verification
A wrong recorded word or a missed first-sample flag shows up in the counters one cycle after the next strobed sample, because the whole delta is off. A wrong neighbour charge shows up only in the coupling count, and only when adjacent wires switch. For that reason the bench uses directed patterns with opposite, same-direction and lone transitions, including transitions on the edge wires. A narrow second instance shares the same stimulus and reaches saturation within a few samples. A wrap in place of a hold is therefore visible at once in its outputs.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // Lateral charge seen by a wire toward one neighbour, in coupling units.
  function automatic logic [1:0] lat_units(edge_t own, edge_t nb);
    logic [1:0] r;
    if (!(own.rise || own.fall))                           r = 2'd0;
    else if (!(nb.rise || nb.fall))                        r = 2'd1;
    else if ((own.rise && nb.rise) || (own.fall && nb.fall)) r = 2'd0;
    else                                                   r = 2'd2;
    return r;
  endfunction

endpackage

// File: rtl/bcm_line.sv
module bcm_line
  import bcm_pkg::*;
#(
  parameter bit HAS_LO = 1'b1,
  parameter bit HAS_HI = 1'b1
) (
  input  edge_t      own_e,
  input  edge_t      lo_e,
  input  edge_t      hi_e,
  output logic       tog,
  output logic [2:0] units
);
  logic [1:0] u_lo;
  logic [1:0] u_hi;

  generate
    if (HAS_LO) begin : g_lo
      assign u_lo = lat_units(own_e, lo_e);
    end else begin : g_no_lo
      assign u_lo = 2'd0;
    end
    if (HAS_HI) begin : g_hi
      assign u_hi = lat_units(own_e, hi_e);
    end else begin : g_no_hi
      assign u_hi = 2'd0;
    end
  endgenerate

  assign tog   = own_e.rise | own_e.fall;
  assign units = {1'b0, u_lo} + {1'b0, u_hi};

  // R4: a wire that does not switch charges nothing
  always_comb begin
    if (!tog) begin
      a_idle_free_r4 : assert (units == 3'd0 || $isunknown(units));
    end
  end
endmodule

// File: rtl/bcm_sum.sv
module bcm_sum #(
  parameter int N     = 16,
  parameter int IN_W  = 3,
  parameter int OUT_W = 7
) (
  input  logic [N*IN_W-1:0] vec,
  output logic [OUT_W-1:0]  total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + OUT_W'(vec[i*IN_W +: IN_W]);
    end
  end
endmodule

// File: rtl/bcm_sat_acc.sv
module bcm_sat_acc #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] acc
);
  localparam int WMAX  = (CNT_W > INC_W) ? CNT_W : INC_W;
  localparam int SUM_W = WMAX + 1;

  logic [CNT_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] top_val;

  assign top_val = SUM_W'({CNT_W{1'b1}});
  assign sum     = SUM_W'(acc_q) + SUM_W'(inc);

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      acc_d = (sum > top_val) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  p_sat_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == {CNT_W{1'b1}} && !clr) |=> (acc_q == {CNT_W{1'b1}}));
  p_no_wrap_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (acc_q >= $past(acc_q)));
  p_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/coupling_cost_mon.sv
module coupling_cost_mon
  import bcm_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 32,
  parameter int ETA_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_vld,
  input  logic [WIDTH-1:0] bus_in,
  input  logic [ETA_W-1:0] eta,
  output logic [CNT_W-1:0] self_cnt,
  output logic [CNT_W-1:0] coup_cnt,
  output logic [CNT_W-1:0] cost_out
);
  localparam int SELF_W = $clog2(WIDTH + 1);
  localparam int COUP_W = $clog2(4 * WIDTH + 1);
  localparam int PROD_W = CNT_W + ETA_W + 1;

  logic [WIDTH-1:0]   prev_q, prev_d;
  logic               armed_q, armed_d;
  edge_t              e_vec [WIDTH];
  logic [WIDTH-1:0]   tog_vec;
  logic [3*WIDTH-1:0] unit_vec;
  logic [SELF_W-1:0]  self_sum;
  logic [COUP_W-1:0]  coup_sum;
  logic               acc_en;
  logic [PROD_W-1:0]  full_cost;

  // previous-word and first-sample state
  always_comb begin
    prev_d  = prev_q;
    armed_d = armed_q;
    if (clr) begin
      armed_d = 1'b0;
    end else if (smp_vld) begin
      prev_d  = bus_in;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  assign acc_en = smp_vld & armed_q & ~clr;

  // per-wire classification and charge
  generate
    for (genvar j = 0; j < WIDTH; j++) begin : g_wire
      assign e_vec[j].rise = ~prev_q[j] &  bus_in[j];
      assign e_vec[j].fall =  prev_q[j] & ~bus_in[j];
    end
    for (genvar j = 0; j < WIDTH; j++) begin : g_line
      localparam int LO = (j > 0) ? j - 1 : 0;
      localparam int HI = (j < WIDTH - 1) ? j + 1 : WIDTH - 1;
      bcm_line #(
        .HAS_LO (j > 0),
        .HAS_HI (j < WIDTH - 1)
      ) u_line (
        .own_e (e_vec[j]),
        .lo_e  (e_vec[LO]),
        .hi_e  (e_vec[HI]),
        .tog   (tog_vec[j]),
        .units (unit_vec[3*j +: 3])
      );
    end
  endgenerate

  bcm_sum #(.N(WIDTH), .IN_W(1), .OUT_W(SELF_W)) u_self_sum (
    .vec   (tog_vec),
    .total (self_sum)
  );

  bcm_sum #(.N(WIDTH), .IN_W(3), .OUT_W(COUP_W)) u_coup_sum (
    .vec   (unit_vec),
    .total (coup_sum)
  );

  bcm_sat_acc #(.CNT_W(CNT_W), .INC_W(SELF_W)) u_self_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (acc_en),
    .inc   (self_sum),
    .acc   (self_cnt)
  );

  bcm_sat_acc #(.CNT_W(CNT_W), .INC_W(COUP_W)) u_coup_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (acc_en),
    .inc   (coup_sum),
    .acc   (coup_cnt)
  );

  // combined figure
  assign full_cost = PROD_W'(self_cnt) + PROD_W'(coup_cnt) * PROD_W'(eta);
  assign cost_out  = (full_cost > PROD_W'({CNT_W{1'b1}})) ? {CNT_W{1'b1}}
                                                          : full_cost[CNT_W-1:0];

  p_first_free_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !armed_q && !clr) |=> ($stable(self_cnt) && $stable(coup_cnt)));
  p_idle_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !clr) |=> ($stable(self_cnt) && $stable(coup_cnt) && $stable(prev_q)));
  p_coup_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    32'(coup_sum) <= 32'(self_sum) * 32'd4);
  p_cost_floor_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    cost_out >= self_cnt);
endmodule

// File: tb/coupling_cost_mon_tb.sv
`timescale 1ns/1ps
module coupling_cost_mon_tb;
  localparam int W     = 16;
  localparam int CW    = 32;
  localparam int SCW   = 6;
  localparam int EW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          smp_vld = 1'b0;
  logic [W-1:0]  bus_in = '0;
  logic [EW-1:0] eta = '0;
  logic [CW-1:0]  self_cnt, coup_cnt, cost_out;
  logic [SCW-1:0] s_self, s_coup, s_cost;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] m_prev = '0;
  bit           m_armed = 1'b0;
  longint       m_self = 0, m_coup = 0, n_self = 0, n_coup = 0;

  always #4 clk = ~clk;

  coupling_cost_mon #(.WIDTH(W), .CNT_W(CW), .ETA_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .bus_in(bus_in),
    .eta(eta), .self_cnt(self_cnt), .coup_cnt(coup_cnt), .cost_out(cost_out));

  coupling_cost_mon #(.WIDTH(W), .CNT_W(SCW), .ETA_W(EW)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .bus_in(bus_in),
    .eta(eta), .self_cnt(s_self), .coup_cnt(s_coup), .cost_out(s_cost));

  function automatic int code(logic p, logic c);
    return int'(c) - int'(p);
  endfunction

  function automatic int zeta(int sj, int sk);
    int a;
    a = sj + sk;
    if (a < 0) a = -a;
    return (sj != 0) ? (2 - a) : 0;
  endfunction

  function automatic void pair_cost(logic [W-1:0] p, logic [W-1:0] c,
                                    output int ds, output int dc);
    int s [W];
    ds = 0; dc = 0;
    for (int j = 0; j < W; j++) s[j] = code(p[j], c[j]);
    for (int j = 0; j < W; j++) begin
      if (s[j] != 0) ds++;
      if (j > 0)     dc += zeta(s[j], s[j-1]);
      if (j < W - 1) dc += zeta(s[j], s[j+1]);
    end
  endfunction

  function automatic longint sat(longint v, int bits);
    longint mx;
    mx = (longint'(1) << bits) - 1;
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " self"},      longint'(self_cnt), m_self);
    chk({tag, " coup"},      longint'(coup_cnt), m_coup);
    chk({tag, " cost R7"},   longint'(cost_out), sat(m_self + longint'(eta) * m_coup, CW));
    chk({tag, " sat self R8"}, longint'(s_self), n_self);
    chk({tag, " sat coup R8"}, longint'(s_coup), n_coup);
    chk({tag, " sat cost R7"}, longint'(s_cost), sat(n_self + longint'(eta) * n_coup, SCW));
  endtask

  // drive one cycle at a negedge, update the model, compare at the next negedge (R9)
  task automatic step(bit v, logic [W-1:0] word, bit c, string tag);
    int ds, dc;
    smp_vld = v; bus_in = word; clr = c;
    if (c) begin
      m_self = 0; m_coup = 0; n_self = 0; n_coup = 0; m_armed = 1'b0;
    end else if (v) begin
      if (m_armed) begin
        pair_cost(m_prev, word, ds, dc);
        m_self = sat(m_self + ds, CW); m_coup = sat(m_coup + dc, CW);
        n_self = sat(n_self + ds, SCW); n_coup = sat(n_coup + dc, SCW);
      end
      m_prev = word; m_armed = 1'b1;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");

    eta = 4'd3;
    // R2: first sample loads only
    step(1'b1, 16'h0000, 1'b0, "R2 first");
    // R3/R4 hand values: lone rise with idle neighbour -> 1,1
    step(1'b1, 16'h0001, 1'b0, "R4 lone");
    chk("R4 lone coup hand", longint'(coup_cnt), 64'd1);
    // opposite pair plus idle: self +2, coup +5
    step(1'b1, 16'h0002, 1'b0, "R4 opposite");
    chk("R3 self hand", longint'(self_cnt), 64'd3);
    chk("R4 coup hand", longint'(coup_cnt), 64'd6);
    step(1'b1, 16'h0005, 1'b0, "R4 triple");
    chk("R4 triple hand", longint'(coup_cnt), 64'd15);
    // R5: strobe low with a different word, no effect
    step(1'b0, 16'hFFFF, 1'b0, "R5 idle");
    chk("R5 hold self", longint'(self_cnt), 64'd6);
    step(1'b1, 16'h0007, 1'b0, "R5 compare to last strobed");
    chk("R5 lone after idle", longint'(coup_cnt), 64'd17);
    // same-direction falls: only the line next to idle line 3 charges
    step(1'b1, 16'h0000, 1'b0, "R4 same dir");
    chk("R4 same dir hand", longint'(coup_cnt), 64'd18);
    chk("R7 cost hand", longint'(cost_out), 64'd64);
    eta = 4'd0;
    @(negedge clk);
    chk("R7 eta zero", longint'(cost_out), 64'd10);
    // edge wire, one neighbour only
    step(1'b1, 16'h8000, 1'b0, "R4 top edge");
    chk("R4 top edge hand", longint'(coup_cnt), 64'd19);
    // R6: clear with strobe in the same cycle drops the sample
    step(1'b1, 16'h1234, 1'b1, "R6 clear");
    chk("R6 clear self", longint'(self_cnt), 64'd0);
    step(1'b1, 16'hFFFF, 1'b0, "R6 R2 rearmed");
    chk("R2 after clear", longint'(coup_cnt), 64'd0);
    // worked 8-bit pattern stream on low byte
    eta = 4'd2;
    step(1'b1, 16'h001C, 1'b0, "R3 pattern a");
    step(1'b1, 16'h0073, 1'b0, "R3 pattern b");
    step(1'b1, 16'h0032, 1'b0, "R3 pattern c");
    step(1'b1, 16'h004D, 1'b0, "R3 pattern d");
    step(1'b1, 16'h0085, 1'b0, "R3 pattern e");
    // R8: alternating words drive the narrow instance to saturation
    eta = 4'd5;
    for (int k = 0; k < 6; k++) begin
      step(1'b1, (k % 2 == 0) ? 16'h5555 : 16'hAAAA, 1'b0, "R8 alternate");
    end
    chk("R8 narrow self pinned", longint'(s_self), 64'd63);
    chk("R8 narrow coup pinned", longint'(s_coup), 64'd63);
    // random streams
    for (int k = 0; k < 600; k++) begin
      eta = EW'($urandom_range(0, 15));
      step(($urandom_range(0, 3) != 0), W'($urandom),
           ($urandom_range(0, 63) == 0), "R3 R4 random");
    end
    // correlated random: single-bit walks
    for (int k = 0; k < 200; k++) begin
      step(1'b1, m_prev ^ (W'(1) << $urandom_range(0, W - 1)), 1'b0, "R4 walk");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule